// File: doc/BRIEF.md
# Programmable ATA PIO Strobe Timer

This block runs one programmed-I/O transfer on a parallel ATA channel per host request. The host presents a request with the target device (master or slave), the direction, the width (8-bit register access or 16-bit data access), whether the command block or the control block is addressed, the 3-bit register address and, for writes, the data. The block then drives the address and chip select, pulses the read or write strobe, and waits out a recovery period. Only after that does it take the next request.

Each of the three phases has its own 4-bit count N, and each phase lasts N+1 clocks. The counts live in a small configuration bank that is written with byte enables over a 32-bit data path. The address-setup counts of both devices share one register: the master count sits in bits [3:0] and the slave count in bits [7:4] of offset 0x48. Each device has three strobe bytes: one for 16-bit reads, one for 16-bit writes and one for 8-bit accesses. Each strobe byte holds the active count in its upper nibble and the recovery count in its lower nibble. At request acceptance the block copies the counts that apply to that request, so a later configuration write cannot change a transfer that is already running. After reset every field is 0xF, which gives the slowest cycle.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset, every timing field reads 0xF. Offset 0x48 reads 0x000000FF, 0x4C reads 0xFFFFFFFF and 0x50 reads 0x0000FFFF. reqReady is high, and both strobes and both chip selects (active low) are high.
- R2: Offset 0x48 holds the master setup count in bits [3:0] and the slave setup count in bits [7:4]. Bits [31:8] read 0 and ignore writes. A read-modify-write that changes one device's nibble leaves the other device's setup timing in effect.
- R3: The strobe bytes sit at these offsets: 0x4C bytes 0 to 3 are master 16-bit read, master 16-bit write, slave 16-bit read and slave 16-bit write. 0x50 byte 0 is master 8-bit and byte 1 is slave 8-bit, and bytes 2 and 3 read 0. In each strobe byte, bits [7:4] are the active count and bits [3:0] are the recovery count.
- R4: A programmed count N gives a phase of exactly N+1 clocks, for every N from 0 to 15, in the setup, active and recovery phases.
- R5: A 16-bit access (reqWide=1) uses the read byte or the write byte that matches reqWrite. An 8-bit access (reqWide=0) uses the 8-bit byte in both directions.
- R6: reqDev=0 selects the master timing set and reqDev=1 selects the slave timing set.
- R7: During setup and active, ataAddr equals the request address, and ataCs0N (reqCtl=0) or ataCs1N (reqCtl=1) is low. Only during active is a strobe low: ataDiorN for reads and ataDiowN for writes. In recovery, both chip selects and both strobes are high.
- R8: doneValid pulses for exactly one clock, in the first recovery cycle. For a 16-bit read, doneData is ataDataIn as sampled on the last active clock. For an 8-bit read, it is the low byte of that sample with zero extension. For a write, it is 0.
- R9: For a write, ataDataOe is high and ataDataOut equals reqWrData throughout setup and active. In every other cycle ataDataOe is low.
- R10: reqReady falls in the clock after acceptance and returns only after the last recovery clock, so a transfer keeps it low for setup+active+recovery+3 clocks. A reqValid raised while busy, with different fields, changes nothing.
- R11: A configuration write made during a transfer does not alter that transfer's timing. It takes effect from the next request.
- R12: A configuration write updates only the bytes whose cfgByteEn bit is set. Writes to unaligned addresses (cfgAddr[1:0] not 0) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte address (dword aligned) |
| cfgByteEn | input | 4 | Byte enables for the configuration write |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data for cfgAddr (combinational) |
| reqValid | input | 1 | Transfer request valid |
| reqReady | output | 1 | Block idle, request accepted when valid |
| reqDev | input | 1 | 0 master, 1 slave |
| reqWrite | input | 1 | 1 write, 0 read |
| reqWide | input | 1 | 1 16-bit data access, 0 8-bit register access |
| reqCtl | input | 1 | 0 command block (CS0), 1 control block (CS1) |
| reqAddr | input | 3 | Register address on the ATA bus |
| reqWrData | input | 16 | Write data |
| doneValid | output | 1 | One-clock completion pulse |
| doneData | output | 16 | Read data returned with doneValid |
| ataAddr | output | 3 | ATA address lines |
| ataCs0N | output | 1 | Command block chip select, active low |
| ataCs1N | output | 1 | Control block chip select, active low |
| ataDiorN | output | 1 | Read strobe, active low |
| ataDiowN | output | 1 | Write strobe, active low |
| ataDataOut | output | 16 | Data driven to the ATA bus |
| ataDataOe | output | 1 | Output enable for ataDataOut |
| ataDataIn | input | 16 | Data received from the ATA bus |

## Verification
The embedded checks assume that the host never changes the request fields in the clock where reqValid and reqReady are both high, and that configuration writes use cfgByteEn to mark the bytes they intend to change. The stimulus holds every request field steady from the clock it raises reqValid until acceptance, then lowers reqValid. A deliberate raise of reqValid with altered fields is made only while reqReady is low. The bench presents ataDataIn before each request and holds it for the whole transfer, so the capture instant cannot pick up a changing bus. Setup values are always written back through a read-modify-write of the shared register.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int PIO_CNT_W = 4;
  localparam int PIO_BYTE_W = 2 * PIO_CNT_W;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACTIVE  = 2'd2,
    PH_RECOVER = 2'd3
  } pio_phase_e;

  // One device's timing set: setup count plus three strobe bytes
  // (upper nibble active count, lower nibble recovery count).
  typedef struct packed {
    logic [PIO_CNT_W-1:0]  setup;
    logic [PIO_BYTE_W-1:0] rd16;
    logic [PIO_BYTE_W-1:0] wr16;
    logic [PIO_BYTE_W-1:0] acc8;
  } pio_dev_timing_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic launch;    // request accepted this clock, latch fields
    logic busOn;     // address/chip select phase (setup + active)
    logic strobeOn;  // active phase, strobe asserted
    logic capture;   // last active clock, sample read data
  } pio_ctl_t;

endpackage

// File: rtl/pio_cfg_bank.sv
module pio_cfg_bank
  import ata_pio_pkg::*;
#(
  parameter int CFG_ADDR_W = 8,
  parameter int CFG_DATA_W = 32,
  parameter int SETUP_OFS  = 'h48,
  parameter int STROBE_OFS = 'h4C,
  parameter int NARROW_OFS = 'h50
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWrEn,
  input  logic [CFG_ADDR_W-1:0]   cfgAddr,
  input  logic [CFG_DATA_W/8-1:0] cfgByteEn,
  input  logic [CFG_DATA_W-1:0]   cfgWrData,
  output logic [CFG_DATA_W-1:0]   cfgRdData,
  output pio_dev_timing_t         masterTiming,
  output pio_dev_timing_t         slaveTiming
);

  localparam int WORD_W       = CFG_ADDR_W - 2;
  localparam int NUM_STROBE   = 4;
  localparam int NUM_NARROW   = 2;
  localparam logic [WORD_W-1:0] SETUP_WORD  = WORD_W'(SETUP_OFS >> 2);
  localparam logic [WORD_W-1:0] STROBE_WORD = WORD_W'(STROBE_OFS >> 2);
  localparam logic [WORD_W-1:0] NARROW_WORD = WORD_W'(NARROW_OFS >> 2);
  localparam logic [PIO_BYTE_W-1:0] SLOW_BYTE = '1;

  logic [PIO_BYTE_W-1:0] setupByte;
  logic [PIO_BYTE_W-1:0] strobeBytes [NUM_STROBE];
  logic [PIO_BYTE_W-1:0] narrowBytes [NUM_NARROW];

  logic aligned, hitSetup, hitStrobe, hitNarrow;

  assign aligned   = (cfgAddr[1:0] == 2'b00);
  assign hitSetup  = cfgWrEn && aligned && (cfgAddr[CFG_ADDR_W-1:2] == SETUP_WORD);
  assign hitStrobe = cfgWrEn && aligned && (cfgAddr[CFG_ADDR_W-1:2] == STROBE_WORD);
  assign hitNarrow = cfgWrEn && aligned && (cfgAddr[CFG_ADDR_W-1:2] == NARROW_WORD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         setupByte <= SLOW_BYTE;
    else if (hitSetup && cfgByteEn[0]) setupByte <= cfgWrData[PIO_BYTE_W-1:0];
  end

  for (genvar b = 0; b < NUM_STROBE; b++) begin : g_strobe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          strobeBytes[b] <= SLOW_BYTE;
      else if (hitStrobe && cfgByteEn[b]) strobeBytes[b] <= cfgWrData[PIO_BYTE_W*b +: PIO_BYTE_W];
    end
  end

  for (genvar b = 0; b < NUM_NARROW; b++) begin : g_narrow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          narrowBytes[b] <= SLOW_BYTE;
      else if (hitNarrow && cfgByteEn[b]) narrowBytes[b] <= cfgWrData[PIO_BYTE_W*b +: PIO_BYTE_W];
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (aligned) begin
      if (cfgAddr[CFG_ADDR_W-1:2] == SETUP_WORD) begin
        cfgRdData[PIO_BYTE_W-1:0] = setupByte;
      end else if (cfgAddr[CFG_ADDR_W-1:2] == STROBE_WORD) begin
        for (int b = 0; b < NUM_STROBE; b++)
          cfgRdData[PIO_BYTE_W*b +: PIO_BYTE_W] = strobeBytes[b];
      end else if (cfgAddr[CFG_ADDR_W-1:2] == NARROW_WORD) begin
        for (int b = 0; b < NUM_NARROW; b++)
          cfgRdData[PIO_BYTE_W*b +: PIO_BYTE_W] = narrowBytes[b];
      end
    end
  end

  assign masterTiming = '{setup: setupByte[PIO_CNT_W-1:0],
                          rd16:  strobeBytes[0],
                          wr16:  strobeBytes[1],
                          acc8:  narrowBytes[0]};
  assign slaveTiming  = '{setup: setupByte[PIO_BYTE_W-1:PIO_CNT_W],
                          rd16:  strobeBytes[2],
                          wr16:  strobeBytes[3],
                          acc8:  narrowBytes[1]};

  // R12
  setup_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hitSetup && cfgByteEn[0]) |=> $stable(setupByte));

  // R12
  strobe_be_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hitStrobe && cfgByteEn[1]) |=> $stable(strobeBytes[1]));

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import ata_pio_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqDev,
  input  logic            reqWrite,
  input  logic            reqWide,
  input  pio_dev_timing_t masterTiming,
  input  pio_dev_timing_t slaveTiming,
  output logic            reqReady,
  output pio_ctl_t        ctl
);

  localparam logic [PIO_CNT_W-1:0] SLOW_CNT = '1;

  pio_phase_e            phase;
  logic [PIO_CNT_W-1:0]  cnt;
  logic [PIO_CNT_W-1:0]  activeLat;
  logic [PIO_CNT_W-1:0]  recoverLat;
  pio_dev_timing_t       selSet;
  logic [PIO_BYTE_W-1:0] selByte;
  logic                  lastTick;
  logic                  accept;

  always_comb begin
    selSet  = reqDev ? slaveTiming : masterTiming;
    selByte = reqWide ? (reqWrite ? selSet.wr16 : selSet.rd16) : selSet.acc8;
  end

  assign lastTick = (cnt == '0);
  assign reqReady = (phase == PH_IDLE);
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      activeLat  <= SLOW_CNT;
      recoverLat <= SLOW_CNT;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            phase      <= PH_SETUP;
            cnt        <= selSet.setup;
            activeLat  <= selByte[PIO_BYTE_W-1:PIO_CNT_W];
            recoverLat <= selByte[PIO_CNT_W-1:0];
          end
        end
        PH_SETUP: begin
          if (lastTick) begin
            phase <= PH_ACTIVE;
            cnt   <= activeLat;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_ACTIVE: begin
          if (lastTick) begin
            phase <= PH_RECOVER;
            cnt   <= recoverLat;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_RECOVER: begin
          if (lastTick) phase <= PH_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.launch   = accept;
    ctl.busOn    = (phase == PH_SETUP) || (phase == PH_ACTIVE);
    ctl.strobeOn = (phase == PH_ACTIVE);
    ctl.capture  = (phase == PH_ACTIVE) && lastTick;
  end

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

  // R7
  strobe_after_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.strobeOn) |-> $past(phase) == PH_SETUP);

  // R10
  idle_from_recover_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqReady) |-> $past(phase) == PH_RECOVER);

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import ata_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  pio_ctl_t          ctl,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic              reqCtl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] ataDataIn,
  output logic [ADDR_W-1:0] ataAddr,
  output logic              ataCs0N,
  output logic              ataCs1N,
  output logic              ataDiorN,
  output logic              ataDiowN,
  output logic [DATA_W-1:0] ataDataOut,
  output logic              ataDataOe,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneData
);

  localparam int NARROW_W = DATA_W / 2;

  logic              writeLat, wideLat, ctlLat;
  logic [ADDR_W-1:0] addrLat;
  logic [DATA_W-1:0] dataLat;
  logic [DATA_W-1:0] readValue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeLat <= 1'b0;
      wideLat  <= 1'b0;
      ctlLat   <= 1'b0;
      addrLat  <= '0;
      dataLat  <= '0;
    end else if (ctl.launch) begin
      writeLat <= reqWrite;
      wideLat  <= reqWide;
      ctlLat   <= reqCtl;
      addrLat  <= reqAddr;
      dataLat  <= reqWrData;
    end
  end

  always_comb begin
    if (writeLat)     readValue = '0;
    else if (wideLat) readValue = ataDataIn;
    else              readValue = {{(DATA_W-NARROW_W){1'b0}}, ataDataIn[NARROW_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneData  <= '0;
    end else begin
      doneValid <= ctl.capture;
      if (ctl.capture) doneData <= readValue;
    end
  end

  assign ataAddr    = ctl.busOn ? addrLat : '0;
  assign ataCs0N    = !(ctl.busOn && !ctlLat);
  assign ataCs1N    = !(ctl.busOn && ctlLat);
  assign ataDiorN   = !(ctl.strobeOn && !writeLat);
  assign ataDiowN   = !(ctl.strobeOn && writeLat);
  assign ataDataOut = dataLat;
  assign ataDataOe  = ctl.busOn && writeLat;

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!ataDiorN && !ataDiowN));

  // R7
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ataDiorN || !ataDiowN) |-> (ataCs0N != ataCs1N));

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ataDiorN |-> !ataDataOe);

  // R9
  write_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ataDiowN) |-> ataDataOe && $past(ataDataOe));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
  import ata_pio_pkg::*;
#(
  parameter int CFG_ADDR_W = 8,
  parameter int CFG_DATA_W = 32,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWrEn,
  input  logic [CFG_ADDR_W-1:0]   cfgAddr,
  input  logic [CFG_DATA_W/8-1:0] cfgByteEn,
  input  logic [CFG_DATA_W-1:0]   cfgWrData,
  output logic [CFG_DATA_W-1:0]   cfgRdData,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqDev,
  input  logic                    reqWrite,
  input  logic                    reqWide,
  input  logic                    reqCtl,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqWrData,
  output logic                    doneValid,
  output logic [DATA_W-1:0]       doneData,
  output logic [ADDR_W-1:0]       ataAddr,
  output logic                    ataCs0N,
  output logic                    ataCs1N,
  output logic                    ataDiorN,
  output logic                    ataDiowN,
  output logic [DATA_W-1:0]       ataDataOut,
  output logic                    ataDataOe,
  input  logic [DATA_W-1:0]       ataDataIn
);

  pio_dev_timing_t masterTiming, slaveTiming;
  pio_ctl_t        ctl;

  pio_cfg_bank #(
    .CFG_ADDR_W(CFG_ADDR_W),
    .CFG_DATA_W(CFG_DATA_W)
  ) cfg_i (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .masterTiming(masterTiming), .slaveTiming(slaveTiming)
  );

  pio_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqDev(reqDev), .reqWrite(reqWrite), .reqWide(reqWide),
    .masterTiming(masterTiming), .slaveTiming(slaveTiming),
    .reqReady(reqReady), .ctl(ctl)
  );

  pio_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqWrite(reqWrite), .reqWide(reqWide), .reqCtl(reqCtl),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .ataDataIn(ataDataIn),
    .ataAddr(ataAddr), .ataCs0N(ataCs0N), .ataCs1N(ataCs1N),
    .ataDiorN(ataDiorN), .ataDiowN(ataDiowN),
    .ataDataOut(ataDataOut), .ataDataOe(ataDataOe),
    .doneValid(doneValid), .doneData(doneData)
  );

endmodule

// File: tb/ata_pio_timer_tb_top.sv
module ata_pio_timer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqDev = 1'b0, reqWrite = 1'b0, reqWide = 1'b0, reqCtl = 1'b0;
  logic [2:0]  reqAddr = '0;
  logic [15:0] reqWrData = '0;
  logic        doneValid;
  logic [15:0] doneData;
  logic [2:0]  ataAddr;
  logic        ataCs0N, ataCs1N, ataDiorN, ataDiowN, ataDataOe;
  logic [15:0] ataDataOut;
  logic [15:0] ataDataIn = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ata_pio_timer dut_i (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .reqValid(reqValid), .reqReady(reqReady), .reqDev(reqDev),
    .reqWrite(reqWrite), .reqWide(reqWide), .reqCtl(reqCtl),
    .reqAddr(reqAddr), .reqWrData(reqWrData),
    .doneValid(doneValid), .doneData(doneData),
    .ataAddr(ataAddr), .ataCs0N(ataCs0N), .ataCs1N(ataCs1N),
    .ataDiorN(ataDiorN), .ataDiowN(ataDiowN),
    .ataDataOut(ataDataOut), .ataDataOe(ataDataOe), .ataDataIn(ataDataIn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // timing byte for sweep step v, device d, kind k (0 rd16, 1 wr16, 2 acc8)
  function automatic logic [7:0] tByte(input int v, input int d, input int k);
    logic [3:0] act, rec;
    act = 4'((v + 3*k + 7*d) % 16);
    rec = 4'((5*v + k + 9*d) % 16);
    return {act, rec};
  endfunction

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d; cfgByteEn = be;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = '0;
  endtask

  task automatic cfgRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdData;
  endtask

  task automatic runTxn(input bit dev, input bit wr, input bit wide, input bit ctlSel,
                        input logic [2:0] a, input logic [15:0] wd, input logic [15:0] rd,
                        input int eS, input int eA, input int eR, input bit disturb);
    int cyc = 0, sCnt = 0, aCnt = 0, rCnt = 0, doneCnt = 0, doneCyc = -1;
    bit seqErr = 0, oeErr = 0, dataErr = 0;
    logic [15:0] expDone;
    logic [15:0] gotDone = '0;
    expDone = wr ? 16'h0 : (wide ? rd : {8'h00, rd[7:0]});
    @(negedge clk);
    reqValid = 1'b1; reqDev = dev; reqWrite = wr; reqWide = wide; reqCtl = ctlSel;
    reqAddr = a; reqWrData = wd; ataDataIn = rd;
    @(posedge clk);
    forever begin
      @(negedge clk);
      cyc++;
      if (reqReady || cyc > 80) break;
      if (!ataDiorN || !ataDiowN) begin
        aCnt++;
        if (rCnt > 0) seqErr = 1;
        if (wr ? (ataDiowN || !ataDiorN) : (ataDiorN || !ataDiowN)) seqErr = 1;
        if (ataAddr != a || ataCs0N != ctlSel || ataCs1N != !ctlSel) seqErr = 1;
        if (ataDataOe != wr || (wr && ataDataOut != wd)) oeErr = 1;
      end else if (!ataCs0N || !ataCs1N) begin
        sCnt++;
        if (aCnt > 0 || rCnt > 0) seqErr = 1;
        if (ataAddr != a || ataCs0N != ctlSel || ataCs1N != !ctlSel) seqErr = 1;
        if (ataDataOe != wr || (wr && ataDataOut != wd)) oeErr = 1;
      end else begin
        rCnt++;
        if (ataDataOe) oeErr = 1;
      end
      if (doneValid) begin
        doneCnt++; doneCyc = cyc; gotDone = doneData;
        if (doneData != expDone) dataErr = 1;
      end
      if (cyc == 1) reqValid = 1'b0;
      if (disturb && cyc == 2) begin
        reqValid = 1'b1; reqAddr = ~a; reqDev = ~dev; reqWrite = ~wr; reqCtl = ~ctlSel;
        cfgWrEn = 1'b1; cfgAddr = 8'h4C; cfgWrData = 32'h0; cfgByteEn = 4'hF;
      end
      if (disturb && cyc == 3) begin
        reqValid = 1'b0; cfgWrEn = 1'b0; cfgByteEn = '0;
      end
    end
    chk(sCnt == eS + 1, "R4", "setup clocks", sCnt, eS + 1);
    chk(aCnt == eA + 1, "R4", "active clocks", aCnt, eA + 1);
    chk(rCnt == eR + 1, "R4", "recovery clocks", rCnt, eR + 1);
    chk(!seqErr, "R7", "strobe/address/select sequence error", seqErr, 0);
    chk(!oeErr, "R9", "write data drive error", oeErr, 0);
    chk(doneCnt == 1 && doneCyc == eS + eA + 3, "R8", "done pulse cycle",
        doneCyc, eS + eA + 3);
    chk(!dataErr, "R8", "done data", gotDone, expDone);
    chk(cyc - 1 == eS + eA + eR + 3, "R10", "busy clocks", cyc - 1, eS + eA + eR + 3);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rdv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(reqReady && ataDiorN && ataDiowN && ataCs0N && ataCs1N && !ataDataOe,
        "R1", "idle outputs", {reqReady, ataDiorN, ataDiowN, ataCs0N, ataCs1N, ataDataOe}, 6'b111110);
    cfgRead(8'h48, rdv); chk(rdv == 32'h000000FF, "R1", "setup reset", rdv, 32'hFF);
    cfgRead(8'h4C, rdv); chk(rdv == 32'hFFFFFFFF, "R1", "strobe reset", rdv, 32'hFFFFFFFF);
    cfgRead(8'h50, rdv); chk(rdv == 32'h0000FFFF, "R1", "narrow reset", rdv, 32'hFFFF);
    runTxn(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0, 16'hBEEF, 15, 15, 15, 1'b0);

    // Sweep: every count value in every phase, both devices, all access kinds (R2 R3 R5 R6)
    for (int v = 0; v < 16; v++) begin
      logic [3:0] mS, sS;
      mS = 4'(v); sS = 4'(15 - v);
      cfgRead(8'h48, rdv); rdv[3:0] = mS; cfgWrite(8'h48, rdv, 4'h1);
      cfgRead(8'h48, rdv); rdv[7:4] = sS; cfgWrite(8'h48, rdv, 4'h1);
      cfgRead(8'h48, rdv);
      chk(rdv == {24'h0, sS, mS}, "R2", "setup nibbles", rdv, {24'h0, sS, mS});
      cfgWrite(8'h4C, {tByte(v,1,1), tByte(v,1,0), tByte(v,0,1), tByte(v,0,0)}, 4'hF);
      cfgWrite(8'h50, {16'hFFFF, tByte(v,1,2), tByte(v,0,2)}, 4'hF);
      cfgRead(8'h50, rdv);
      chk(rdv == {16'h0, tByte(v,1,2), tByte(v,0,2)}, "R3", "narrow layout",
          rdv, {16'h0, tByte(v,1,2), tByte(v,0,2)});
      for (int d = 0; d < 2; d++) begin
        for (int k = 0; k < 4; k++) begin
          bit wr, wide;
          int kind, s;
          logic [7:0] tb;
          wr   = (k == 1) || (k == 3);
          wide = (k < 2);
          kind = wide ? (wr ? 1 : 0) : 2;
          tb   = tByte(v, d, kind);
          s    = (d == 0) ? v : 15 - v;
          // R5 R6: expected counts follow the device and access kind
          runTxn(d[0], wr, wide, k[0] ^ d[0], 3'(v + k), 16'(16'hA5C3 ^ (v * 257 + k)),
                 16'(16'h5A3C + v * 131 + k * 17 + d), s, int'(tb[7:4]), int'(tb[3:0]), 1'b0);
        end
      end
    end

    // R12: byte enables and alignment
    cfgWrite(8'h4C, 32'h11223344, 4'b0010);
    cfgRead(8'h4C, rdv);
    chk(rdv == {tByte(15,1,1), tByte(15,1,0), 8'h33, tByte(15,0,0)}, "R12", "single byte write",
        rdv, {tByte(15,1,1), tByte(15,1,0), 8'h33, tByte(15,0,0)});
    cfgWrite(8'h48, 32'hFFFFFF77, 4'b1110);
    cfgWrite(8'h49, 32'h00000077, 4'hF);
    cfgRead(8'h48, rdv);
    chk(rdv == 32'h0000000F, "R12", "setup untouched by disabled/unaligned writes", rdv, 32'hF);

    // R2: changing only the slave nibble keeps the master setup timing
    cfgRead(8'h48, rdv); rdv[7:4] = 4'h9; cfgWrite(8'h48, rdv, 4'h1);
    cfgWrite(8'h4C, 32'h0000_0023, 4'h1);
    runTxn(1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 16'h0, 16'h1234, 15, 2, 3, 1'b0);

    // R10 R11: busy request and mid-transfer config write are ignored for this transfer
    runTxn(1'b0, 1'b0, 1'b1, 1'b0, 3'd5, 16'h0, 16'hC0DE, 15, 2, 3, 1'b1);
    // R11: new values apply to the next request
    runTxn(1'b0, 1'b0, 1'b1, 1'b0, 3'd5, 16'h0, 16'h0F0F, 15, 0, 0, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule